// File: doc/BRIEF.md
# Switching Surface Override Controller

This block sits between a fixed-frequency PWM controller and the gate driver of a synchronous buck stage. On every oversampling tick (for example a 25 MHz tick, which gives 32 ticks per 780 kHz switching period), it receives two signed inputs: the output-voltage error code (measured minus reference) and a capacitor-current estimate. Close to regulation it passes the PWM switch command straight through. The PWM controller is never paused or altered by this block.

When a large disturbance shows up, the block takes over the switch. A disturbance here means that the voltage error and the current estimate both sit at least a threshold away from zero, in the direction of a worsening excursion. The block then forces the switch fully on or fully off. It evaluates a linear switching surface, `surface = verr + icap * 2^SHIFT`, on every tick. A crossing of that surface flips the forced level once. A second crossing back through zero hands control back to the PWM command.

An enable input holds the block in pass-through, for example while the converter soft-starts. The surface is computed with a shift and an add and is clamped to a signed internal width. That internal width is also brought out for observation.

Top module: `surface_override`

## Requirements
- R1: In pass-through mode (`mode_o` = 0), `sw_cmd` equals `pwm_cmd` in the same cycle, with no register in between.
- R2: `surf_o` always equals `verr + icap * 2^SHIFT` for the present inputs, whenever that sum fits in SURF_W signed bits.
- R3: From pass-through, if `enable` is 1 and `tick` is 1 at a rising edge, and both `verr <= -THRESH` and `icap <= -THRESH` hold, the mode becomes forced-on-first (`mode_o` = 1). In that mode, and in forced-on-second (`mode_o` = 4), `sw_cmd` is 1.
- R4: From pass-through, if `enable` is 1 and `tick` is 1 at a rising edge, and both `verr >= THRESH` and `icap >= THRESH` hold, the mode becomes forced-off-first (`mode_o` = 3). In that mode, and in forced-off-second (`mode_o` = 2), `sw_cmd` is 0.
- R5: In forced-on-first, a tick with `surf_o >= 0` moves the mode to forced-off-second (`mode_o` = 2). Forced-off-second is reached from no other mode.
- R6: In forced-off-second, a tick with `surf_o < 0` returns the mode to pass-through.
- R7: The mirrored path has every sign inverted. In forced-off-first, a tick with `surf_o <= 0` moves the mode to forced-on-second (`mode_o` = 4), which is reached from no other mode. In forced-on-second, a tick with `surf_o > 0` returns the mode to pass-through.
- R8: With `enable` at 0, the mode is pass-through after the next rising edge, from any mode, and no override is entered.
- R9: With `enable` at 1 and `tick` at 0, the mode does not change at a rising edge, whatever the other inputs are.
- R10: A synchronous active-high `rst` puts the mode in pass-through at the next rising edge.
- R11: When the exact sum falls outside the SURF_W signed range, `surf_o` clamps to the largest or smallest representable value of the same sign, and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling strobe; modes advance only when it is high |
| enable | input | 1 | Override allowed; low holds pass-through |
| pwm_cmd | input | 1 | Switch command from the PWM controller |
| verr | input | EW | Signed voltage error, measured minus reference, in ADC LSBs |
| icap | input | IW | Signed capacitor-current estimate |
| sw_cmd | output | 1 | Switch command to the gate driver |
| mode_o | output | 3 | Mode code: 0 pass, 1 on-first, 2 off-second, 3 off-first, 4 on-second |
| surf_o | output | SURF_W | Clamped switching-surface value of the present inputs |

## Verification
A wrong mode shows at `sw_cmd` in the same cycle it is taken. For example, a stuck override hides `pwm_cmd` toggles, and a missed hand-back pins the switch at a rail. `mode_o` exposes the mode one edge after the deciding tick. A clamp or shift fault shows at once on `surf_o`. It also skews which tick flips the forced level, so the bench follows random walks of the error and current around the surface and compares every cycle. Directed runs cover both override sequences, tick gaps, enable drops and clamping at both extremes.

// File: rtl/surface_override_pkg.sv
package surface_override_pkg;
  typedef enum logic [2:0] {
    MODE_PASS  = 3'd0,
    MODE_ON_A  = 3'd1,
    MODE_OFF_B = 3'd2,
    MODE_OFF_A = 3'd3,
    MODE_ON_B  = 3'd4
  } mode_e;
endpackage

// File: rtl/surface_calc.sv
module surface_calc #(
  parameter int EW = 8,
  parameter int IW = 10,
  parameter int SHIFT = 3,
  parameter int SURF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [EW-1:0]     verr,
  input  logic signed [IW-1:0]     icap,
  output logic signed [SURF_W-1:0] surf,
  output logic                     surf_neg,
  output logic                     surf_zero
);
  localparam int MAGW   = (IW + SHIFT > EW) ? IW + SHIFT : EW;
  localparam int WIDE_W = (MAGW + 1 > SURF_W) ? MAGW + 1 : SURF_W + 1;
  localparam logic signed [WIDE_W-1:0] SMAX =
    WIDE_W'((64'sd1 <<< (SURF_W - 1)) - 64'sd1);
  localparam logic signed [WIDE_W-1:0] SMIN = -SMAX - 1;

  // exact sum of the shifted current and the error, never overflows
  function automatic logic signed [WIDE_W-1:0] exact_sum(
    input logic signed [EW-1:0] v, input logic signed [IW-1:0] i);
    logic signed [WIDE_W-1:0] vx, ix;
    vx = {{(WIDE_W-EW){v[EW-1]}}, v};
    ix = {{(WIDE_W-IW){i[IW-1]}}, i};
    return (ix <<< SHIFT) + vx;
  endfunction

  function automatic logic signed [SURF_W-1:0] clamp(
    input logic signed [WIDE_W-1:0] x);
    if (x > SMAX) return SMAX[SURF_W-1:0];
    if (x < SMIN) return SMIN[SURF_W-1:0];
    return x[SURF_W-1:0];
  endfunction

  logic signed [WIDE_W-1:0] wide;
  assign wide      = exact_sum(verr, icap);
  assign surf      = clamp(wide);
  assign surf_neg  = surf[SURF_W-1];
  assign surf_zero = (surf == '0);

  AST_SURF_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (surf[SURF_W-1] == wide[WIDE_W-1]) && ((surf == '0) == (wide == '0))); // R11
endmodule

// File: rtl/entry_detect.sv
module entry_detect #(
  parameter int EW = 8,
  parameter int IW = 10,
  parameter int THRESH = 1
) (
  input  logic signed [EW-1:0] verr,
  input  logic signed [IW-1:0] icap,
  output logic                 want_on,
  output logic                 want_off
);
  localparam logic signed [EW-1:0] VT = EW'(THRESH);
  localparam logic signed [IW-1:0] IT = IW'(THRESH);

  // undervoltage still falling: push energy in; overvoltage still rising: cut it
  assign want_on  = (verr <= -VT) && (icap <= -IT);
  assign want_off = (verr >=  VT) && (icap >=  IT);
endmodule

// File: rtl/override_fsm.sv
module override_fsm
  import surface_override_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  enable,
  input  logic  want_on,
  input  logic  want_off,
  input  logic  surf_neg,
  input  logic  surf_zero,
  output mode_e mode
);
  mode_e state_q, state_d;
  logic  s_ge0, s_lt0, s_le0, s_gt0;

  assign s_lt0 = surf_neg;
  assign s_ge0 = !surf_neg;
  assign s_le0 = surf_neg || surf_zero;
  assign s_gt0 = !surf_neg && !surf_zero;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = MODE_PASS;
    end else if (tick) begin
      case (state_q)
        MODE_PASS:  if (want_on) state_d = MODE_ON_A;
                    else if (want_off) state_d = MODE_OFF_A;
        MODE_ON_A:  if (s_ge0) state_d = MODE_OFF_B;
        MODE_OFF_B: if (s_lt0) state_d = MODE_PASS;
        MODE_OFF_A: if (s_le0) state_d = MODE_ON_B;
        MODE_ON_B:  if (s_gt0) state_d = MODE_PASS;
        default:    state_d = MODE_PASS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= MODE_PASS;
    else     state_q <= state_d;
  end

  assign mode = state_q;

  AST_RESET_PASS: assert property (@(posedge clk)
    rst |=> state_q == MODE_PASS); // R10
  AST_DISABLE_PASS: assert property (@(posedge clk) disable iff (rst)
    !enable |=> state_q == MODE_PASS); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (enable && !tick) |=> $stable(state_q)); // R9
  AST_ENTER_ON: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_PASS && enable && tick && want_on) |=> state_q == MODE_ON_A); // R3
  AST_ENTER_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_PASS && enable && tick && want_off) |=> state_q == MODE_OFF_A); // R4
  AST_OFFB_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_OFF_B && $past(state_q) != MODE_OFF_B) |-> $past(state_q) == MODE_ON_A); // R5
  AST_OFFB_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_OFF_B && enable && tick && surf_neg) |=> state_q == MODE_PASS); // R6
  AST_ONB_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (state_q == MODE_ON_B && $past(state_q) != MODE_ON_B) |-> $past(state_q) == MODE_OFF_A); // R7
endmodule

// File: rtl/cmd_select.sv
module cmd_select
  import surface_override_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  pwm_cmd,
  output logic  sw_cmd
);
  always_comb begin
    case (mode)
      MODE_ON_A, MODE_ON_B:   sw_cmd = 1'b1;
      MODE_OFF_A, MODE_OFF_B: sw_cmd = 1'b0;
      default:                sw_cmd = pwm_cmd;
    endcase
  end

  AST_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_PASS |-> sw_cmd == pwm_cmd); // R1
  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ON_A || mode == MODE_ON_B) |-> sw_cmd); // R3
  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF_A || mode == MODE_OFF_B) |-> !sw_cmd); // R4
endmodule

// File: rtl/surface_override.sv
module surface_override
  import surface_override_pkg::*;
#(
  parameter int EW = 8,
  parameter int IW = 10,
  parameter int SHIFT = 3,
  parameter int SURF_W = 12,
  parameter int THRESH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              enable,
  input  logic              pwm_cmd,
  input  logic [EW-1:0]     verr,
  input  logic [IW-1:0]     icap,
  output logic              sw_cmd,
  output logic [2:0]        mode_o,
  output logic [SURF_W-1:0] surf_o
);
  logic signed [EW-1:0]     verr_s;
  logic signed [IW-1:0]     icap_s;
  logic signed [SURF_W-1:0] surf;
  logic                     surf_neg, surf_zero, want_on, want_off;
  mode_e                    mode;

  assign verr_s = $signed(verr);
  assign icap_s = $signed(icap);

  surface_calc #(.EW(EW), .IW(IW), .SHIFT(SHIFT), .SURF_W(SURF_W)) surf_i (
    .clk(clk), .rst(rst), .verr(verr_s), .icap(icap_s),
    .surf(surf), .surf_neg(surf_neg), .surf_zero(surf_zero));

  entry_detect #(.EW(EW), .IW(IW), .THRESH(THRESH)) entry_i (
    .verr(verr_s), .icap(icap_s), .want_on(want_on), .want_off(want_off));

  override_fsm fsm_i (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable),
    .want_on(want_on), .want_off(want_off),
    .surf_neg(surf_neg), .surf_zero(surf_zero), .mode(mode));

  cmd_select sel_i (
    .clk(clk), .rst(rst), .mode(mode), .pwm_cmd(pwm_cmd), .sw_cmd(sw_cmd));

  assign mode_o = mode;
  assign surf_o = surf;
endmodule

// File: tb/surface_override_tb_top.sv
`timescale 1ns/1ps
module surface_override_tb_top;
  localparam int EW = 8, IW = 10, SHIFT = 3, SURF_W = 12, THRESH = 1;
  localparam int SMAX = (1 <<< (SURF_W - 1)) - 1;
  localparam int SMIN = -(1 <<< (SURF_W - 1));

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, enable = 1'b0, pwm_cmd = 1'b0;
  logic [EW-1:0] verr = '0;
  logic [IW-1:0] icap = '0;
  logic sw_cmd;
  logic [2:0] mode_o;
  logic [SURF_W-1:0] surf_o;

  int checks = 0, errors = 0;
  int exp_mode = 0;
  string mode_tag = "R10";
  bit finished = 0;

  always #5 clk = ~clk;

  surface_override #(.EW(EW), .IW(IW), .SHIFT(SHIFT), .SURF_W(SURF_W), .THRESH(THRESH)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .enable(enable), .pwm_cmd(pwm_cmd),
    .verr(verr), .icap(icap), .sw_cmd(sw_cmd), .mode_o(mode_o), .surf_o(surf_o));

  function automatic int exp_surface(input int v, input int i);
    int s = v + i * (2 ** SHIFT);
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    return s;
  endfunction

  function automatic bit clamped(input int v, input int i);
    int s = v + i * (2 ** SHIFT);
    return (s > SMAX) || (s < SMIN);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input logic pw, input int v, input int i);
    int exp_sw;
    check(mode_tag, int'(mode_o), exp_mode);
    if (exp_mode == 0) exp_sw = int'(pw);
    else if (exp_mode == 1 || exp_mode == 4) exp_sw = 1;
    else exp_sw = 0;
    check(exp_mode == 0 ? "R1" : (exp_sw == 1 ? "R3" : "R4"), int'(sw_cmd), exp_sw);
    check(clamped(v, i) ? "R11" : "R2", int'($signed(surf_o)), exp_surface(v, i));
  endtask

  task automatic advance_model(input logic r, input logic en, input logic tk,
                               input int v, input int i);
    int s = exp_surface(v, i);
    if (r) begin exp_mode = 0; mode_tag = "R10"; return; end
    if (!en) begin exp_mode = 0; mode_tag = "R8"; return; end
    if (!tk) begin mode_tag = "R9"; return; end
    case (exp_mode)
      0: if (v <= -THRESH && i <= -THRESH) begin exp_mode = 1; mode_tag = "R3"; end
         else if (v >= THRESH && i >= THRESH) begin exp_mode = 3; mode_tag = "R4"; end
         else mode_tag = "R1";
      1: begin mode_tag = "R5"; if (s >= 0) exp_mode = 2; end
      2: begin mode_tag = "R6"; if (s < 0) exp_mode = 0; end
      3: begin mode_tag = "R7"; if (s <= 0) exp_mode = 4; end
      4: begin mode_tag = "R7"; if (s > 0) exp_mode = 0; end
      default: exp_mode = 0;
    endcase
  endtask

  task automatic step(input logic r, input logic en, input logic tk, input logic pw,
                      input int v, input int i, input bit chk);
    @(negedge clk);
    rst = r; enable = en; tick = tk; pwm_cmd = pw;
    verr = EW'(v); icap = IW'(i);
    #1;
    if (chk) check_outputs(pw, v, i);
    advance_model(r, en, tk, v, i);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v = 0, i = 0;
    void'($urandom(32'd4711));
    // r10_ reset
    repeat (3) step(1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 1, 0, 0, 1);          // R10 mode 0 after reset, R1 pass
    step(0, 1, 1, 0, 0, 0, 1);          // R1 pwm low passes
    // R3 / R5 / R6 on-then-off sequence
    step(0, 1, 1, 0, -5, -3, 1);        // enter on-first
    step(0, 1, 1, 0, -5, -1, 1);        // surf -13, stays on
    step(0, 1, 0, 0, -5, 2, 1);         // R9 no tick, surf 11 but hold
    step(0, 1, 1, 1, -5, 2, 1);         // surf 11 >= 0 -> off-second
    step(0, 1, 1, 1, -5, 1, 1);         // surf 3 stays off
    step(0, 1, 1, 1, -8, 1, 1);         // surf 0 stays off
    step(0, 1, 1, 1, -5, -1, 1);        // surf -13 -> pass
    step(0, 1, 1, 1, 0, 0, 1);          // R1 back in pass
    // R4 / R7 mirrored sequence
    step(0, 1, 1, 1, 4, 2, 1);          // enter off-first
    step(0, 1, 1, 1, 4, 1, 1);          // surf 12 stays
    step(0, 1, 1, 0, 0, 0, 1);          // surf 0 -> on-second
    step(0, 1, 1, 0, -8, 1, 1);         // surf 0 stays on
    step(0, 1, 1, 0, 3, 0, 1);          // surf 3 -> pass
    step(0, 1, 1, 1, 0, 0, 1);
    // threshold edge: only one of the two beyond threshold
    step(0, 1, 1, 1, -1, 0, 1);
    step(0, 1, 1, 1, 0, -1, 1);
    step(0, 1, 1, 1, -1, -1, 1);        // exactly THRESH enters on
    // R8 enable drop from override, no entry while low
    step(0, 0, 1, 0, -9, -9, 1);
    step(0, 0, 1, 0, -9, -9, 1);
    step(0, 0, 0, 1, 9, 9, 1);
    // R10 reset from inside an override
    step(0, 1, 1, 0, 9, 9, 1);
    step(1, 1, 1, 0, 9, 9, 1);
    step(0, 1, 0, 0, 0, 0, 1);
    // R11 clamp extremes
    step(0, 1, 0, 0, 127, 511, 1);
    step(0, 1, 0, 0, -128, -512, 1);
    step(0, 1, 0, 1, 100, 250, 1);
    step(0, 1, 0, 1, -100, -250, 1);
    step(0, 1, 0, 1, 0, 0, 1);
    // random walks around the surface
    for (int n = 0; n < 6000; n++) begin
      logic en, tk, pw;
      v += int'($urandom_range(0, 6)) - 3;
      i += int'($urandom_range(0, 4)) - 2;
      if (v > 40) v = 40;
      if (v < -40) v = -40;
      if (i > 12) i = 12;
      if (i < -12) i = -12;
      if ($urandom_range(0, 49) == 0) begin
        v = int'($urandom_range(0, 255)) - 128;
        i = int'($urandom_range(0, 1023)) - 512;
      end
      en = ($urandom_range(0, 39) != 0);
      tk = ($urandom_range(0, 3) != 0);
      pw = $urandom_range(0, 1) == 1;
      step(0, en, tk, pw, v, i, 1);
      if ($urandom_range(0, 49) == 0) begin v = 0; i = 0; end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule